// File: doc/BRIEF.md
# Interlaced Field Parity Detector

This block tells the two fields of an interlaced picture apart from a digital composite sync stream that has already been separated from the video. It times every gap between sync pulses. Gaps of a full line length reach a programmable threshold. The shorter gaps of the vertical interval, the equalising and broad-pulse spacing, do not reach it. A parity flop counts the short gaps that follow the last full-length gap. A field whose scan ends on half a line adds one extra short gap, so the parity on the two fields differs.

A separate vertical detector supplies a one-cycle strobe at the start of each vertical pulse. On that strobe the parity is turned into a field flag, which is then held for the whole field. The flag is hidden, and the valid output stays low, until enough strobes have been seen after reset for the parity history to be trusted. The sync and strobe inputs can pass through an optional bank of synchroniser stages, which all have the same delay.

Top module: `field_parity_detector`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `field_odd` and `field_valid` are both 0.
- R2: The gap length is the number of consecutive cycles with `csync` low. A high cycle clears it. A gap counts as full-length when its length is greater than or equal to `gap_thresh`. A gap of `gap_thresh-1` cycles is short and a gap of `gap_thresh` cycles is full-length.
- R3: Each leading edge of sync (low to high) that ends a short gap inverts the internal parity.
- R4: Once a gap in progress reaches `gap_thresh`, the parity clears. A strobe placed later in that same gap therefore sees a cleared parity. A leading edge that ends a full-length gap leaves the parity cleared.
- R5: On a `vstart` strobe the flag latches 1 (odd field) when the number of short-gap leading edges since the last full-length gap is even. It latches 0 (even field) when that number is odd. The new value shows one cycle after the strobe and does not change again until the next strobe.
- R6: `field_valid` rises in the cycle after the LOCK_STROBES-th strobe (default 2) following reset, and stays high. While it is low, `field_odd` reads 0.
- R7: With `gap_thresh` = 0 every gap is full-length, so every strobe latches 1.
- R8: The gap count saturates at its all-ones value. A gap longer than the counter range is still full-length when `gap_thresh` is all ones.
- R9: When a strobe arrives in the same cycle as a leading edge, the flag uses the parity from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csync | input | 1 | Digital composite sync, 1 = sync asserted |
| vstart | input | 1 | One-cycle strobe at the start of the vertical pulse |
| gap_thresh | input | CNT_W | Gap length, in cycles, that counts as a full line |
| field_odd | output | 1 | Field flag: 1 odd, 0 even; 0 while not valid |
| field_valid | output | 1 | Flag is trustworthy |

## Verification
Synthetic fields are built from full-length lines, a chosen number of short gaps and a broad pulse, and then strobed. Runs with an even and an odd count of short gaps show that the flag follows parity and not simply the presence of a vertical interval. Gaps of exactly `gap_thresh-1` and `gap_thresh` cycles probe the threshold boundary. A strobe placed early in a long gap and another placed late in it show when the clear takes effect. A strobe that coincides with a sync edge, a zero threshold and an all-ones threshold with a gap longer than the counter range cover the remaining orderings. A behavioural model in the bench is compared against the outputs on every cycle.

// File: rtl/fpd_pkg.sv
package fpd_pkg;
  // Per-cycle sync event summary passed from the gap timer to the parity flop.
  typedef struct packed {
    logic lead;      // low-to-high sync edge this cycle
    logic long_gap;  // gap ended (or ending) was full-length
    logic full_now;  // still inside a gap that has reached the threshold
  } sync_evt_t;
endpackage

// File: rtl/fpd_input_sync.sv
module fpd_input_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/fpd_gap_timer.sv
module fpd_gap_timer
  import fpd_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  input  logic [CNT_W-1:0] thresh,
  output logic [CNT_W-1:0] gap_cnt,
  output sync_evt_t        evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic sync_q;
  logic reached;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= 1'b0;
      gap_cnt <= '0;
    end else begin
      sync_q <= sync_in;
      if (sync_in)
        gap_cnt <= '0;
      else if (gap_cnt != CNT_MAX)
        gap_cnt <= gap_cnt + 1'b1;
    end
  end

  assign reached      = (gap_cnt >= thresh);
  assign evt.lead     = sync_in & ~sync_q;
  assign evt.long_gap = reached;
  assign evt.full_now = ~sync_in & reached;
endmodule

// File: rtl/fpd_parity_flop.sv
module fpd_parity_flop
  import fpd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  sync_evt_t evt,
  output logic      par
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      par <= 1'b0;
    else if (evt.lead)
      par <= evt.long_gap ? 1'b0 : ~par;
    else if (evt.full_now)
      par <= 1'b0;
  end
endmodule

// File: rtl/fpd_field_latch.sv
module fpd_field_latch #(
  parameter int LOCK_STROBES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic par,
  output logic field_odd,
  output logic field_valid
);
  localparam int SW = $clog2(LOCK_STROBES + 2);
  localparam logic [SW-1:0] LOCK_N = SW'(LOCK_STROBES);

  logic [SW-1:0] seen;
  logic          odd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen  <= '0;
      odd_q <= 1'b0;
    end else if (strobe) begin
      odd_q <= ~par;
      if (seen != LOCK_N) seen <= seen + 1'b1;
    end
  end

  assign field_valid = (seen == LOCK_N);
  assign field_odd   = odd_q & field_valid;
endmodule

// File: rtl/field_parity_detector.sv
module field_parity_detector
  import fpd_pkg::*;
#(
  parameter int CNT_W          = 12,
  parameter int IN_SYNC_STAGES = 0,
  parameter int LOCK_STROBES   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csync,
  input  logic             vstart,
  input  logic [CNT_W-1:0] gap_thresh,
  output logic             field_odd,
  output logic             field_valid
);
  logic             csync_s;
  logic             vstart_s;
  logic [CNT_W-1:0] gap_cnt;
  logic             par;
  sync_evt_t        evt;

  generate
    if (IN_SYNC_STAGES == 0) begin : g_direct
      assign csync_s  = csync;
      assign vstart_s = vstart;
    end else begin : g_sync
      logic [1:0] sq;
      fpd_input_sync #(.STAGES(IN_SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({csync, vstart}), .q(sq)
      );
      assign csync_s  = sq[1];
      assign vstart_s = sq[0];
    end
  endgenerate

  fpd_gap_timer #(.CNT_W(CNT_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .sync_in(csync_s), .thresh(gap_thresh),
    .gap_cnt(gap_cnt), .evt(evt)
  );

  fpd_parity_flop u_par (
    .clk(clk), .rst_n(rst_n), .evt(evt), .par(par)
  );

  fpd_field_latch #(.LOCK_STROBES(LOCK_STROBES)) u_lat (
    .clk(clk), .rst_n(rst_n), .strobe(vstart_s), .par(par),
    .field_odd(field_odd), .field_valid(field_valid)
  );
endmodule

// File: rtl/fpd_checker.sv
module fpd_checker #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             csync_s,
  input logic             vstart_s,
  input logic [CNT_W-1:0] gap_thresh,
  input logic [CNT_W-1:0] gap_cnt,
  input logic             par,
  input logic             field_odd,
  input logic             field_valid
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  assert_flag_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !field_valid |-> !field_odd);

  assert_valid_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    field_valid |=> field_valid);

  assert_valid_on_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(field_valid) |-> $past(vstart_s));

  assert_flag_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !vstart_s |=> $stable(field_odd));

  assert_gap_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
    csync_s |=> (gap_cnt == '0));

  assert_gap_counts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!csync_s && gap_cnt != CMAX) |=> (gap_cnt == $past(gap_cnt) + 1'b1));

  assert_gap_saturates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!csync_s && gap_cnt == CMAX) |=> (gap_cnt == CMAX));

  assert_short_toggles_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(csync_s) && gap_cnt < gap_thresh) |=> (par != $past(par)));

  assert_full_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!csync_s && gap_cnt >= gap_thresh) |=> !par);
endmodule

bind field_parity_detector fpd_checker #(.CNT_W(CNT_W)) u_fpd_chk (
  .clk(clk), .rst_n(rst_n), .csync_s(csync_s), .vstart_s(vstart_s),
  .gap_thresh(gap_thresh), .gap_cnt(gap_cnt), .par(par),
  .field_odd(field_odd), .field_valid(field_valid)
);

// File: tb/field_parity_detector_test.sv
module field_parity_detector_test;
  localparam int W    = 12;
  localparam int CMAX = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         csync = 1'b0;
  logic         vstart = 1'b0;
  logic [W-1:0] th = 12'd40;
  logic         field_odd, field_valid;

  int    vectors = 0;
  int    errors  = 0;
  string tag = "R1";

  // behavioural reference state
  int m_prev = 0, m_gap = 0, m_par = 0, m_seen = 0, m_odd = 0;

  always #4 clk = ~clk;

  field_parity_detector #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .csync(csync), .vstart(vstart),
    .gap_thresh(th), .field_odd(field_odd), .field_valid(field_valid)
  );

  always @(posedge clk) begin : model
    int lead, longg;
    if (!rst_n) begin
      m_prev = 0; m_gap = 0; m_par = 0; m_seen = 0; m_odd = 0;
    end else begin
      lead  = (csync && m_prev == 0) ? 1 : 0;
      longg = (m_gap >= int'(th)) ? 1 : 0;
      if (vstart) begin
        m_odd = (m_par == 0) ? 1 : 0;
        if (m_seen < 2) m_seen++;
      end
      if (lead == 1)              m_par = (longg == 1) ? 0 : 1 - m_par;
      else if (!csync && longg == 1) m_par = 0;
      m_gap  = csync ? 0 : ((m_gap < CMAX) ? m_gap + 1 : CMAX);
      m_prev = csync ? 1 : 0;
    end
  end

  always @(negedge clk) begin : compare
    logic ev, eo;
    ev = (m_seen >= 2);
    eo = ev && (m_odd == 1);
    vectors++;
    if (field_valid !== ev || field_odd !== eo) begin
      errors++;
      $display("FAIL %s model: odd=%0b valid=%0b expected odd=%0b valid=%0b",
               tag, field_odd, field_valid, eo, ev);
    end
  end

  task automatic expect_flag(string t, logic eo, logic ev);
    vectors++;
    if (field_odd !== eo || field_valid !== ev) begin
      errors++;
      $display("FAIL %s directed: odd=%0b valid=%0b expected odd=%0b valid=%0b",
               t, field_odd, field_valid, eo, ev);
    end
  endtask

  task automatic hold(logic s, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); csync = s; vstart = 1'b0;
    end
  endtask

  task automatic strobe_gap(int n);
    @(negedge clk); csync = 1'b0; vstart = 1'b1;
    hold(1'b0, n - 1);
  endtask

  task automatic prelude();
    repeat (3) begin hold(1'b1, 4); hold(1'b0, 60); end
  endtask

  // k short-gap leading edges after the last full line, then strobe
  task automatic field(int k);
    prelude();
    repeat (k) begin hold(1'b1, 4); hold(1'b0, 25); end
    hold(1'b1, 20);
    strobe_gap(10);
    hold(1'b0, 50);
  endtask

  // strobe lands on the k-th short-gap leading edge
  task automatic coincide(int k);
    prelude();
    repeat (k) begin hold(1'b1, 4); hold(1'b0, 25); end
    @(negedge clk); csync = 1'b1; vstart = 1'b1;
    hold(1'b1, 3);
    hold(1'b0, 60);
  endtask

  // three short edges, then strobe `pre` cycles into a long gap
  task automatic gap_position(int pre);
    prelude();
    repeat (3) begin hold(1'b1, 4); hold(1'b0, 25); end
    hold(1'b1, 4);
    hold(1'b0, pre);
    strobe_gap(10);
    hold(1'b0, 50);
  endtask

  task automatic boundary(int g);
    prelude();
    hold(1'b1, 4);
    hold(1'b0, g);
    hold(1'b1, 20);
    strobe_gap(10);
    hold(1'b0, 50);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin : stim
    repeat (5) @(negedge clk);
    tag = "R1";
    expect_flag("R1", 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_flag("R1", 1'b0, 1'b0);

    tag = "R6";
    field(6);  expect_flag("R6", 1'b0, 1'b0);   // first strobe: not yet valid
    tag = "R5";
    field(6);  expect_flag("R5", 1'b1, 1'b1);   // even short count -> odd
    field(7);  expect_flag("R5", 1'b0, 1'b1);   // odd short count -> even
    field(6);  expect_flag("R5", 1'b1, 1'b1);
    tag = "R3";
    field(1);  expect_flag("R3", 1'b0, 1'b1);
    field(2);  expect_flag("R3", 1'b1, 1'b1);
    tag = "R9";
    coincide(7); expect_flag("R9", 1'b1, 1'b1); // 6 edges counted before
    coincide(6); expect_flag("R9", 1'b0, 1'b1); // 5 edges counted before
    tag = "R4";
    gap_position(5);  expect_flag("R4", 1'b0, 1'b1); // before clear
    gap_position(50); expect_flag("R4", 1'b1, 1'b1); // after clear
    tag = "R2";
    boundary(39); expect_flag("R2", 1'b0, 1'b1);     // thresh-1: short
    boundary(40); expect_flag("R2", 1'b1, 1'b1);     // thresh: full
    tag = "R7";
    th = 12'd0;
    field(7); expect_flag("R7", 1'b1, 1'b1);
    field(1); expect_flag("R7", 1'b1, 1'b1);
    tag = "R8";
    th = 12'hFFF;
    hold(1'b1, 4); hold(1'b0, 5000); hold(1'b1, 4);
    hold(1'b0, 100); hold(1'b1, 4);
    strobe_gap(10);
    expect_flag("R8", 1'b0, 1'b1);                   // one short after saturated gap
    hold(1'b0, 5000); hold(1'b1, 4);
    strobe_gap(10);
    expect_flag("R8", 1'b1, 1'b1);                   // saturated gap is full-length
    th = 12'd40;
    hold(1'b0, 20);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule